// File: doc/BRIEF.md
# Integer ALU with status flags

This block performs the integer add and subtract family of operations on 8-bit or 16-bit operands. It also produces the six status flags that later conditional logic reads. Each cycle in which `op_valid` is high, it takes an opcode, a width select, a destination operand, a source operand and an incoming carry. On the next rising clock edge it registers the result, a result write-enable and the updated flag vector.

A per-operation update mask controls the flag register. An operation changes only the flags its mask selects, and every other flag keeps its value. Increment and decrement therefore leave carry untouched, and the two sign-extension operations leave every flag untouched. Compare sets flags exactly as subtract does, but it writes no result.

The operand width is a parameter (`DATA_W`, default 16). The narrow mode works on the low half of that width. The sign-extension result is twice `DATA_W` wide, so the word-to-doubleword form fits.

Top module: `int_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, `result` is cleared to 0, `res_we` to 0 and `flags` to 0. The flag bit positions are: [0] carry CF, [1] parity PF, [2] auxiliary carry AF, [3] zero ZF, [4] sign SF, [5] overflow OF.
- R2: Opcode 0 (add) gives dst+src. Opcode 1 (add with carry) gives dst+src+`carry_in`. CF is the carry out of the top bit of the selected width. The result and flags appear one clock after `op_valid`, with `res_we` high for that one cycle.
- R3: Opcode 2 (subtract) gives dst−src. Opcode 3 (subtract with borrow) gives dst−src−`carry_in`. CF is set when the true difference is negative.
- R4: For every add- and subtract-type operation, AF is the carry out of bit 3 (for adds) or the borrow out of bit 3 (for subtracts).
- R5: SF is the top bit of the selected width. ZF is set when the selected-width result is zero. OF is set when the signed result lies outside the signed range of the selected width.
- R6: PF is set when the low 8 bits of the result hold an even number of ones.
- R7: Opcode 5 (increment, dst+1) and opcode 6 (decrement, dst−1) update AF, OF, PF, SF and ZF, and keep CF at its previous value.
- R8: Opcode 4 (compare) updates all six flags as subtract does. It keeps `res_we` low and leaves `result` unchanged. Equal operands give CF=0, ZF=1. A larger unsigned dst gives CF=0, ZF=0. A smaller dst gives CF=1, ZF=0.
- R9: Opcode 7 (negate) gives 0−dst and updates all six flags. CF is set exactly when dst is nonzero.
- R10: Opcode 8 outputs bits [7:0] of dst with bit 7 copied into bits [15:8]. Opcode 9 outputs dst with bit 15 copied into bits [31:16]. Both ignore `wide`, raise `res_we` and leave all flags unchanged.
- R11: `wide`=1 selects 16-bit operation and `wide`=0 selects 8-bit operation. In 8-bit mode the upper operand bits are ignored and `result` bits above bit 7 are zero.
- R12: With `op_valid` low, or with opcodes 10 to 15, `res_we` is low and `result` and `flags` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select |
| wide | input | 1 | 1 = full width, 0 = half width |
| dst_in | input | DATA_W | Destination operand |
| src_in | input | DATA_W | Source operand |
| carry_in | input | 1 | Incoming carry or borrow for the carry-using forms |
| result | output | 2*DATA_W | Registered result |
| res_we | output | 1 | Result write-enable, one cycle per writing operation |
| flags | output | 6 | Registered status flags |

## Verification
The bench uses the default `DATA_W` of 16. This makes the 8-bit mode small enough to sweep every destination and source pair for add with carry and for subtract with borrow, with the incoming carry alternating, and with junk placed in the upper operand bits. Increment, decrement, negate and both sign extensions are swept over every byte value. The 16-bit mode is covered by pseudo-random pairs plus the signed and unsigned boundary values. The carry-keeping rule is tested with CF deliberately left both set and clear beforehand.

// File: rtl/alu_pkg.sv
// Shared opcode encoding, flag bit positions and decoder control record.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_CMP = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_NEG = 4'd7,
        OP_SXB = 4'd8,
        OP_SXW = 4'd9
    } alu_op_e;

    localparam int FLAG_N  = 6;
    localparam int FL_CF   = 0;
    localparam int FL_PF   = 1;
    localparam int FL_AF   = 2;
    localparam int FL_ZF   = 3;
    localparam int FL_SF   = 4;
    localparam int FL_OF   = 5;

    localparam logic [FLAG_N-1:0] MASK_ALL  = '1;
    localparam logic [FLAG_N-1:0] MASK_NOCF = ~(FLAG_N'(1) << FL_CF);
    localparam logic [FLAG_N-1:0] MASK_NONE = '0;

    typedef struct packed {
        logic              sub;       // invert source and carry into the adder
        logic              use_cin;   // carry_in participates
        logic              a_zero;    // first adder operand forced to zero
        logic              b_one;     // second adder operand forced to one
        logic              b_dst;     // second adder operand taken from dst
        logic              sext;      // result comes from the sign extender
        logic              sext_dw;   // word-to-doubleword extension
        logic              we;        // operation writes a result
        logic [FLAG_N-1:0] mask;      // flags this operation updates
    } alu_ctl_t;

endpackage

// File: rtl/alu_ctl.sv
// Opcode decoder: maps an opcode to adder operand steering, result source,
// write-enable and flag-update mask. Purely combinational.
// Assumes unassigned opcodes must behave as a no-op.
module alu_ctl
    import alu_pkg::*;
(
    input  logic [3:0] op,
    output alu_ctl_t   ctl
);

    // Decode the opcode into its control record.
    always_comb begin
        ctl = '0;
        case (alu_op_e'(op))
            OP_ADD: begin ctl.we = 1'b1; ctl.mask = MASK_ALL; end
            OP_ADC: begin ctl.we = 1'b1; ctl.use_cin = 1'b1; ctl.mask = MASK_ALL; end
            OP_SUB: begin ctl.we = 1'b1; ctl.sub = 1'b1; ctl.mask = MASK_ALL; end
            OP_SBB: begin
                ctl.we = 1'b1; ctl.sub = 1'b1; ctl.use_cin = 1'b1; ctl.mask = MASK_ALL;
            end
            OP_CMP: begin ctl.sub = 1'b1; ctl.mask = MASK_ALL; end
            OP_INC: begin ctl.we = 1'b1; ctl.b_one = 1'b1; ctl.mask = MASK_NOCF; end
            OP_DEC: begin
                ctl.we = 1'b1; ctl.sub = 1'b1; ctl.b_one = 1'b1; ctl.mask = MASK_NOCF;
            end
            OP_NEG: begin
                ctl.we = 1'b1; ctl.sub = 1'b1; ctl.a_zero = 1'b1; ctl.b_dst = 1'b1;
                ctl.mask = MASK_ALL;
            end
            OP_SXB: begin ctl.we = 1'b1; ctl.sext = 1'b1; ctl.mask = MASK_NONE; end
            OP_SXW: begin
                ctl.we = 1'b1; ctl.sext = 1'b1; ctl.sext_dw = 1'b1; ctl.mask = MASK_NONE;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
// Shared adder/subtractor with flag generation for two operand widths.
// Subtraction is a + ~b + ~borrow; the carry into each bit is recovered
// from sum ^ a ^ b, so the narrow carry and overflow need no second adder.
// Assumes HALF_W >= 8 (parity covers the low 8 bits) and HALF_W > 4.
module alu_addsub
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              wide,
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic [FLAG_N-1:0] flg
);

    localparam int HALF_W = DATA_W / 2;
    localparam int PAR_W  = 8;

    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic [DATA_W:0]   sum;
    logic [DATA_W:0]   cy_in;   // cy_in[i] = carry into bit i; cy_in[DATA_W] = carry out

    // Condition the second operand and carry for subtraction.
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        sum   = {1'b0, a} + {1'b0, b_eff} + (DATA_W + 1)'(c_eff);
    end

    // Recover the carry entering every bit position.
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_cy
            assign cy_in[gi] = sum[gi] ^ a[gi] ^ b_eff[gi];
        end
    endgenerate
    assign cy_in[DATA_W] = sum[DATA_W];

    // Select the width-dependent result and form the six flags.
    always_comb begin
        logic msb_cy_out;
        logic msb_cy_in;
        res        = wide ? sum[DATA_W-1:0] : {{(DATA_W-HALF_W){1'b0}}, sum[HALF_W-1:0]};
        msb_cy_out = wide ? cy_in[DATA_W]   : cy_in[HALF_W];
        msb_cy_in  = wide ? cy_in[DATA_W-1] : cy_in[HALF_W-1];
        flg        = '0;
        flg[FL_CF] = msb_cy_out ^ sub;
        flg[FL_AF] = cy_in[4] ^ sub;
        flg[FL_OF] = msb_cy_out ^ msb_cy_in;
        flg[FL_SF] = wide ? res[DATA_W-1] : res[HALF_W-1];
        flg[FL_ZF] = (res == '0);
        flg[FL_PF] = ~^res[PAR_W-1:0];
    end

endmodule

// File: rtl/alu_sext.sv
// Sign extender: half-width to full-width, or full-width to double-width.
// Combinational; assumes the result bus is twice the operand width.
module alu_sext #(
    parameter int DATA_W = 16
) (
    input  logic                dword,
    input  logic [DATA_W-1:0]   d,
    output logic [2*DATA_W-1:0] q
);

    localparam int HALF_W = DATA_W / 2;

    // Replicate the selected sign bit upward.
    always_comb begin
        if (dword)
            q = {{DATA_W{d[DATA_W-1]}}, d};
        else
            q = {{DATA_W{1'b0}}, {(DATA_W-HALF_W){d[HALF_W-1]}}, d[HALF_W-1:0]};
    end

endmodule

// File: rtl/int_alu.sv
// Integer ALU top: decodes the opcode, steers operands into the shared
// adder, merges new flags under the per-operation mask and registers the
// result, write-enable and flags. One clock of latency.
// Assumes operands are stable in the cycle op_valid is high.
module int_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [3:0]          op_code,
    input  logic                wide,
    input  logic [DATA_W-1:0]   dst_in,
    input  logic [DATA_W-1:0]   src_in,
    input  logic                carry_in,
    output logic [2*DATA_W-1:0] result,
    output logic                res_we,
    output logic [FLAG_N-1:0]   flags
);

    localparam int RES_W = 2 * DATA_W;

    alu_ctl_t            ctl;
    logic [DATA_W-1:0]   opa, opb;
    logic                opc;
    logic [DATA_W-1:0]   add_res;
    logic [FLAG_N-1:0]   add_flg;
    logic [RES_W-1:0]    sext_res;
    logic [RES_W-1:0]    res_next;
    logic [FLAG_N-1:0]   flags_next;
    logic [RES_W-1:0]    result_q;
    logic                we_q;
    logic [FLAG_N-1:0]   flags_q;

    alu_ctl u_ctl (
        .op  (op_code),
        .ctl (ctl)
    );

    // Steer destination, source and carry into the adder inputs.
    always_comb begin
        opa = ctl.a_zero ? '0 : dst_in;
        if (ctl.b_one)      opb = DATA_W'(1);
        else if (ctl.b_dst) opb = dst_in;
        else                opb = src_in;
        opc = ctl.use_cin & carry_in;
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .wide (wide),
        .sub  (ctl.sub),
        .a    (opa),
        .b    (opb),
        .cin  (opc),
        .res  (add_res),
        .flg  (add_flg)
    );

    alu_sext #(.DATA_W(DATA_W)) u_sext (
        .dword (ctl.sext_dw),
        .d     (dst_in),
        .q     (sext_res)
    );

    // Pick the result source and merge flags under the update mask.
    always_comb begin
        res_next   = ctl.sext ? sext_res : {{(RES_W-DATA_W){1'b0}}, add_res};
        flags_next = (ctl.mask & add_flg) | (~ctl.mask & flags_q);
    end

    // Register result, write-enable and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            we_q     <= 1'b0;
            flags_q  <= '0;
        end else begin
            we_q <= op_valid & ctl.we;
            if (op_valid && ctl.we) result_q <= res_next;
            if (op_valid)           flags_q  <= flags_next;
        end
    end

    assign result = result_q;
    assign res_we = we_q;
    assign flags  = flags_q;

endmodule

// File: rtl/int_alu_chk.sv
// Port-level checker for int_alu, attached with bind.
module int_alu_chk
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic [3:0]          op_code,
    input logic                wide,
    input logic [DATA_W-1:0]   dst_in,
    input logic [2*DATA_W-1:0] result,
    input logic                res_we,
    input logic [FLAG_N-1:0]   flags
);

    localparam int HALF_W = DATA_W / 2;

    a_r7_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == OP_INC || op_code == OP_DEC)
        |=> flags[FL_CF] == $past(flags[FL_CF]));

    a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_CMP |=> !res_we && $stable(result));

    a_r9_neg_carry: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_NEG && wide
        |=> flags[FL_CF] == ($past(dst_in) != '0));

    a_r10_sext_flags: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == OP_SXB || op_code == OP_SXW) |=> $stable(flags) && res_we);

    a_r11_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !wide && op_code <= 4'd7 && op_code != OP_CMP
        |=> result[2*DATA_W-1:HALF_W] == '0);

    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_we && $stable(flags) && $stable(result));

endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .wide     (wide),
    .dst_in   (dst_in),
    .result   (result),
    .res_we   (res_we),
    .flags    (flags)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;

    localparam int W = 16;

    localparam int ADD = 0, ADC = 1, SUB = 2, SBB = 3, CMP = 4,
                   INC = 5, DEC = 6, NEG = 7, SXB = 8, SXW = 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_valid;
    logic [3:0]    op_code;
    logic          wide;
    logic [W-1:0]  dst_in, src_in;
    logic          carry_in;
    logic [2*W-1:0] result;
    logic          res_we;
    logic [5:0]    flags;

    int n_checks = 0;
    int n_fail   = 0;
    logic [2*W-1:0] exp_res;
    logic           exp_we;
    logic [5:0]     exp_flg;
    logic [15:0]    lfsr = 16'hACE1;

    always #10 clk = ~clk;

    int_alu #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .wide(wide), .dst_in(dst_in), .src_in(src_in), .carry_in(carry_in),
        .result(result), .res_we(res_we), .flags(flags)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic check(input string req);
        n_checks++;
        if (result !== exp_res || res_we !== exp_we || flags !== exp_flg) begin
            n_fail++;
            $display("FAIL %s op=%0d wide=%0b dst=%h src=%h cin=%0b: got res=%h we=%0b flg=%b exp res=%h we=%0b flg=%b",
                     req, op_code, wide, dst_in, src_in, carry_in,
                     result, res_we, flags, exp_res, exp_we, exp_flg);
        end
    endtask

    // Arithmetic reference: kind 0 = add, 1 = subtract.
    task automatic model_arith(input int kind, input int n, input int a, input int b,
                               input int c, input bit keep_cf, input bit write);
        int mask = (1 << n) - 1;
        int half = 1 << (n - 1);
        int full, sa, sb, sv, nib, r;
        logic [7:0] r8;
        logic [5:0] nf;
        sa = (a >= half) ? a - (1 << n) : a;
        sb = (b >= half) ? b - (1 << n) : b;
        if (kind == 0) begin
            full = a + b + c;
            nib  = (a & 15) + (b & 15) + c;
            sv   = sa + sb + c;
        end else begin
            full = a - b - c;
            nib  = (a & 15) - (b & 15) - c;
            sv   = sa - sb - c;
        end
        r  = full & mask;
        r8 = r[7:0];
        nf[0] = (kind == 0) ? (full > mask) : (full < 0);
        nf[1] = ~^r8;
        nf[2] = (kind == 0) ? (nib > 15) : (nib < 0);
        nf[3] = (r == 0);
        nf[4] = r[n-1];
        nf[5] = (sv > half - 1) || (sv < -half);
        if (keep_cf) nf[0] = exp_flg[0];
        exp_flg = nf;
        exp_we  = write;
        if (write) exp_res = (2*W)'(r);
    endtask

    task automatic run_op(input int op, input bit w, input int d, input int s,
                          input bit ci, input string req);
        int n  = w ? 16 : 8;
        int mk = (1 << n) - 1;
        int dm = d & mk;
        int sm = s & mk;
        logic [15:0] d16 = 16'(d);
        case (op)
            ADD: model_arith(0, n, dm, sm, 0, 0, 1);
            ADC: model_arith(0, n, dm, sm, int'(ci), 0, 1);
            SUB: model_arith(1, n, dm, sm, 0, 0, 1);
            SBB: model_arith(1, n, dm, sm, int'(ci), 0, 1);
            CMP: model_arith(1, n, dm, sm, 0, 0, 0);
            INC: model_arith(0, n, dm, 1, 0, 1, 1);
            DEC: model_arith(1, n, dm, 1, 0, 1, 1);
            NEG: model_arith(1, n, 0, dm, 0, 0, 1);
            SXB: begin
                exp_res = {16'h0, {8{d16[7]}}, d16[7:0]};
                exp_we  = 1'b1;
            end
            SXW: begin
                exp_res = {{16{d16[15]}}, d16};
                exp_we  = 1'b1;
            end
            default: exp_we = 1'b0;
        endcase
        op_valid = 1'b1;
        op_code  = 4'(op);
        wide     = w;
        dst_in   = 16'(d);
        src_in   = 16'(s);
        carry_in = ci;
        @(negedge clk);
        check(req);
    endtask

    task automatic idle_cycle(input int d, input string req);
        op_valid = 1'b0;
        op_code  = 4'(d);
        dst_in   = 16'(d);
        src_in   = 16'(d * 7);
        carry_in = 1'b1;
        exp_we   = 1'b0;
        @(negedge clk);
        check(req);
    endtask

    function automatic int next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr);
    endfunction

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; wide = 1'b0;
        dst_in = '0; src_in = '0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        exp_res = '0; exp_we = 1'b0; exp_flg = '0;
        check("R1 reset");
        rst_n = 1'b1;

        // R2 R4 R5 R6 R11: exhaustive 8-bit add with carry, junk in upper bits
        for (int d = 0; d < 256; d++)
            for (int s = 0; s < 256; s++)
                run_op(ADC, 1'b0, ((d * 37) & 255) << 8 | d, ((s * 91) & 255) << 8 | s,
                       bit'((d ^ s) & 1), "R2 R4 R5 R6 R11 adc8");

        // R3 R4 R5: exhaustive 8-bit subtract with borrow
        for (int d = 0; d < 256; d++)
            for (int s = 0; s < 256; s++)
                run_op(SBB, 1'b0, d, s | 16'h5A00, bit'((d + s) & 1), "R3 R4 R5 sbb8");

        // R2 R3 R5: 16-bit corners and pseudo-random pairs
        run_op(ADD, 1'b1, 16'h7FFF, 1, 0, "R2 R5 add16 ovf");
        run_op(ADD, 1'b1, 16'hFFFF, 1, 0, "R2 R5 add16 wrap");
        run_op(SUB, 1'b1, 16'h8000, 1, 0, "R3 R5 sub16 ovf");
        run_op(SUB, 1'b1, 0, 1, 0, "R3 sub16 borrow");
        run_op(ADC, 1'b1, 16'hFFFF, 0, 1, "R2 adc16 carry");
        for (int i = 0; i < 3000; i++) begin
            int a = next_rand();
            int b = next_rand();
            run_op(ADD + (i % 4), 1'b1, a, b, bit'(i[2]), "R2 R3 R5 R6 rand16");
        end

        // R8: compare ordering cases in both widths
        run_op(ADD, 1'b1, 16'h1234, 0, 0, "R2 preload");
        run_op(CMP, 1'b1, 16'h4321, 16'h4321, 0, "R8 cmp equal");
        run_op(CMP, 1'b1, 16'h9000, 16'h0001, 0, "R8 cmp greater");
        run_op(CMP, 1'b1, 16'h0001, 16'h9000, 0, "R8 cmp less");
        for (int d = 0; d < 256; d++)
            run_op(CMP, 1'b0, d, (d * 13 + 7) & 255, 0, "R8 cmp8");

        // R7: increment and decrement with CF set and clear beforehand
        for (int d = 0; d < 256; d++) begin
            run_op(SUB, 1'b0, 0, d & 1, 0, "R3 set cf");
            run_op(INC, 1'b0, d, 0, 1, "R7 inc8");
            run_op(DEC, 1'b0, d, 0, 1, "R7 dec8");
        end
        run_op(SUB, 1'b1, 0, 1, 0, "R3 set cf");
        run_op(INC, 1'b1, 16'hFFFF, 0, 0, "R7 inc16 wrap");
        run_op(INC, 1'b1, 16'h7FFF, 0, 0, "R7 inc16 ovf");
        run_op(ADD, 1'b1, 0, 0, 0, "R2 clear cf");
        run_op(DEC, 1'b1, 0, 0, 0, "R7 dec16 wrap");
        run_op(DEC, 1'b1, 16'h8000, 0, 0, "R7 dec16 ovf");

        // R9: negate
        for (int d = 0; d < 256; d++)
            run_op(NEG, 1'b0, d | 16'h3300, 0, 0, "R9 neg8");
        run_op(NEG, 1'b1, 0, 0, 0, "R9 neg16 zero");
        run_op(NEG, 1'b1, 16'h8000, 0, 0, "R9 neg16 min");
        run_op(NEG, 1'b1, 16'h0001, 0, 0, "R9 neg16 one");

        // R10: sign extensions leave flags, ignore wide
        run_op(SUB, 1'b0, 16'h80, 1, 0, "R3 flag pattern");
        for (int d = 0; d < 256; d++) begin
            run_op(SXB, bit'(d & 1), (d << 8) ^ d, 0, 0, "R10 sxb");
            run_op(SXW, bit'(d & 1), (d << 8) | ((d * 5) & 255), 0, 0, "R10 sxw");
        end

        // R12: idle cycles and unassigned opcodes
        run_op(ADD, 1'b1, 16'h8001, 16'h8001, 0, "R2 flag pattern");
        for (int i = 0; i < 16; i++) idle_cycle(i * 4099, "R12 idle");
        for (int op = 10; op < 16; op++)
            run_op(op, 1'b1, 16'hFFFF, 16'hFFFF, 1, "R12 unassigned");
        idle_cycle(3, "R12 idle after");

        finish_run();
    end

endmodule